// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Guard-Extended Accumulator

This block multiplies two 16-bit operands and combines the product with a 40-bit accumulator register in a single clock cycle. The product can replace the accumulator, be added to it, or be subtracted from it. Each operand is read as either two's complement or unsigned, independently of the other. A fractional mode doubles the product so that two 1.15 fractions give a 1.31 result aligned with the accumulator's upper half.

The accumulator holds eight guard bits above a 32-bit working range, so a long sum of products can run past 32 bits without losing information. A flag reports when the value has left the signed 32-bit range. A separate saturate operation then clamps the register to the nearest signed 32-bit limit. The result of an arithmetic operation can be rounded at bit 16, either biased or round-half-to-even. The register is presented as three fields: guard, high half and low half.

Top module: `mac40_unit`

## Requirements
- R1: After reset the accumulator reads zero in all three fields and the overflow flag is low.
- R2: When `clr` is high, the accumulator is zero after the next edge, whatever the operation code.
- R3: Operation code 1 (load) writes the product to the accumulator, sign-extended to 40 bits. Each operand is taken as two's complement when its signed-mode input is high and as unsigned otherwise.
- R4: Operation code 2 adds the product to the accumulator and code 3 subtracts it. Both wrap modulo 2^40.
- R5: With `frac_mode` high, the product is doubled before it is used by codes 1, 2 and 3.
- R6: Operation code 0, and codes 5 to 7, leave the accumulator unchanged.
- R7: With `rnd_en` high, the result of codes 1, 2 and 3 has 0x8000 added before it is stored (biased rounding).
- R8: With `rnd_en` and `rnd_unbiased` both high, a result whose bits 15:0 equal 0x8000 before rounding has bit 16 cleared after rounding. Other results round as in R7.
- R9: `ovf` is high exactly when accumulator bits 39 to 31 are not all equal.
- R10: Operation code 4 (saturate) sets the accumulator to 0x00_7FFF_FFFF when `ovf` is high and bit 39 is 0. It sets it to 0xFF_8000_0000 when `ovf` is high and bit 39 is 1. When `ovf` is low it leaves the accumulator unchanged.
- R11: `acc_guard` carries accumulator bits 39:32, `acc_hi` bits 31:16 and `acc_lo` bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of the accumulator, overrides `op` |
| op | input | 3 | Operation code: 0 hold, 1 load, 2 add, 3 subtract, 4 saturate |
| opnd_x | input | 16 | First operand |
| opnd_y | input | 16 | Second operand |
| x_signed | input | 1 | First operand is two's complement |
| y_signed | input | 1 | Second operand is two's complement |
| frac_mode | input | 1 | Double the product |
| rnd_en | input | 1 | Round the arithmetic result at bit 16 |
| rnd_unbiased | input | 1 | Use round-half-to-even instead of biased rounding |
| acc_guard | output | 8 | Accumulator bits 39:32 |
| acc_hi | output | 16 | Accumulator bits 31:16 |
| acc_lo | output | 16 | Accumulator bits 15:0 |
| ovf | output | 1 | Accumulator lies outside the signed 32-bit range |

## Verification
The hardest states to reach are those at the ends of the accumulator's range: values past 32 bits in either direction, where saturation must pick the correct limit, and a full wrap through 2^40. Random operands almost never produce these. The bench therefore builds them on purpose. It adds near-full-scale fractional products repeatedly until the positive or negative range is exceeded, then saturates. It also runs a long chain of unsigned doubled maximum products so that the 40-bit register wraps. The rounding tie needs a low half of exactly 0x8000. The bench produces it from small products with bit 16 both clear and set, so that both outcomes of round-half-to-even are exercised.

// File: rtl/mac40_pkg.sv
package mac40_pkg;
  localparam int OPND_W  = 16;
  localparam int ACCUM_W = 40;
  localparam int WORK_W  = 32;
  localparam int OP_W    = 3;

  typedef enum logic [OP_W-1:0] {
    OP_HOLD = 3'd0,
    OP_LOAD = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_SAT  = 3'd4
  } mac_op_e;
endpackage

// File: rtl/mac40_mult.sv
module mac40_mult #(
  parameter int IN_W  = mac40_pkg::OPND_W,
  parameter int ACC_W = mac40_pkg::ACCUM_W
) (
  input  logic [IN_W-1:0]  a,
  input  logic [IN_W-1:0]  b,
  input  logic             a_signed,
  input  logic             b_signed,
  input  logic             dbl,
  output logic [ACC_W-1:0] prod
);
  localparam int EXT_W  = IN_W + 1;
  localparam int PROD_W = 2 * EXT_W;

  function automatic logic signed [PROD_W-1:0] ext_mul(
    input logic [IN_W-1:0] x, input logic xs,
    input logic [IN_W-1:0] y, input logic ys);
    logic signed [EXT_W-1:0] xe;
    logic signed [EXT_W-1:0] ye;
    xe = {xs & x[IN_W-1], x};
    ye = {ys & y[IN_W-1], y};
    return PROD_W'(xe) * PROD_W'(ye);
  endfunction

  logic signed [PROD_W-1:0] raw;
  logic [ACC_W-1:0]         wide;

  always_comb begin
    raw  = ext_mul(a, a_signed, b, b_signed);
    wide = {{(ACC_W-PROD_W){raw[PROD_W-1]}}, raw};
    prod = dbl ? {wide[ACC_W-2:0], 1'b0} : wide;
  end
endmodule

// File: rtl/mac40_round.sv
module mac40_round #(
  parameter int ACC_W  = mac40_pkg::ACCUM_W,
  parameter int HALF_W = mac40_pkg::WORK_W / 2
) (
  input  logic [ACC_W-1:0] val_in,
  input  logic             enable,
  input  logic             half_even,
  output logic [ACC_W-1:0] val_out,
  output logic             tie_hit
);
  localparam logic [ACC_W-1:0]  HALF_LSB = ACC_W'(1) << (HALF_W - 1);
  localparam logic [HALF_W-1:0] TIE_PAT  = HALF_W'(1) << (HALF_W - 1);

  function automatic logic [ACC_W-1:0] do_round(
    input logic [ACC_W-1:0] v, input logic tie);
    logic [ACC_W-1:0] r;
    r = v + HALF_LSB;
    if (tie) r[HALF_W] = 1'b0;
    return r;
  endfunction

  always_comb begin
    tie_hit = enable && half_even && (val_in[HALF_W-1:0] == TIE_PAT);
    val_out = enable ? do_round(val_in, tie_hit) : val_in;
  end
endmodule

// File: rtl/mac40_sat.sv
module mac40_sat #(
  parameter int ACC_W = mac40_pkg::ACCUM_W,
  parameter int RES_W = mac40_pkg::WORK_W
) (
  input  logic [ACC_W-1:0] acc,
  output logic             out_of_range,
  output logic [ACC_W-1:0] clamp_val
);
  localparam int TOP_W = ACC_W - RES_W + 1;
  localparam logic [ACC_W-1:0] POS_LIM = (ACC_W'(1) << (RES_W - 1)) - ACC_W'(1);
  localparam logic [ACC_W-1:0] NEG_LIM = ~POS_LIM;

  logic [TOP_W-1:0] top;

  always_comb begin
    top          = acc[ACC_W-1:RES_W-1];
    out_of_range = !((&top) || !(|top));
    clamp_val    = acc[ACC_W-1] ? NEG_LIM : POS_LIM;
  end
endmodule

// File: rtl/mac40_unit.sv
module mac40_unit
  import mac40_pkg::*;
#(
  parameter int IN_W  = OPND_W,
  parameter int ACC_W = ACCUM_W,
  parameter int RES_W = WORK_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic [OP_W-1:0]        op,
  input  logic [IN_W-1:0]        opnd_x,
  input  logic [IN_W-1:0]        opnd_y,
  input  logic                   x_signed,
  input  logic                   y_signed,
  input  logic                   frac_mode,
  input  logic                   rnd_en,
  input  logic                   rnd_unbiased,
  output logic [ACC_W-RES_W-1:0] acc_guard,
  output logic [RES_W/2-1:0]     acc_hi,
  output logic [RES_W/2-1:0]     acc_lo,
  output logic                   ovf
);
  localparam int HALF_W = RES_W / 2;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] prod;
  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] rounded;
  logic [ACC_W-1:0] clamp_val;
  logic [ACC_W-1:0] acc_d;
  logic             arith_op;
  logic             sat_fire;
  logic             tie_evt;
  logic             hold_op;

  mac40_mult #(.IN_W(IN_W), .ACC_W(ACC_W)) u_mult (
    .a(opnd_x), .b(opnd_y), .a_signed(x_signed), .b_signed(y_signed),
    .dbl(frac_mode), .prod(prod)
  );

  always_comb begin
    arith_op = (op == OP_LOAD) || (op == OP_ADD) || (op == OP_SUB);
    hold_op  = !arith_op && (op != OP_SAT);
    unique case (op)
      OP_LOAD: sum = prod;
      OP_ADD:  sum = acc_q + prod;
      OP_SUB:  sum = acc_q - prod;
      default: sum = acc_q;
    endcase
  end

  mac40_round #(.ACC_W(ACC_W), .HALF_W(HALF_W)) u_round (
    .val_in(sum), .enable(rnd_en && arith_op), .half_even(rnd_unbiased),
    .val_out(rounded), .tie_hit(tie_evt)
  );

  mac40_sat #(.ACC_W(ACC_W), .RES_W(RES_W)) u_sat (
    .acc(acc_q), .out_of_range(ovf), .clamp_val(clamp_val)
  );

  assign sat_fire = (op == OP_SAT) && ovf;

  always_comb begin
    if (clr)           acc_d = '0;
    else if (sat_fire) acc_d = clamp_val;
    else if (arith_op) acc_d = rounded;
    else               acc_d = acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc_guard = acc_q[ACC_W-1:RES_W];
  assign acc_hi    = acc_q[RES_W-1:HALF_W];
  assign acc_lo    = acc_q[HALF_W-1:0];

  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == '0));

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && op == OP_LOAD && !rnd_en) |=> (acc_q == $past(prod)));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && hold_op) |=> $stable(acc_q));

  p_tie_even_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && tie_evt) |=> !acc_q[HALF_W]);

  p_sat_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && sat_fire) |=> !ovf);

  p_sat_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && op == OP_SAT && !ovf) |=> $stable(acc_q));
endmodule

// File: tb/mac40_unit_bench.sv
`timescale 1ns/1ps
module mac40_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic [2:0]  op = '0;
  logic [15:0] opnd_x = '0;
  logic [15:0] opnd_y = '0;
  logic        x_signed = 1'b0, y_signed = 1'b0, frac_mode = 1'b0;
  logic        rnd_en = 1'b0, rnd_unbiased = 1'b0;
  logic [7:0]  acc_guard;
  logic [15:0] acc_hi, acc_lo;
  logic        ovf;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  longint mdl = 0;

  localparam longint SPAN = 64'sd1 <<< 40;

  always #5 clk = ~clk;

  mac40_unit u_mac40_unit (
    .clk(clk), .rst_n(rst_n), .clr(clr), .op(op), .opnd_x(opnd_x), .opnd_y(opnd_y),
    .x_signed(x_signed), .y_signed(y_signed), .frac_mode(frac_mode),
    .rnd_en(rnd_en), .rnd_unbiased(rnd_unbiased),
    .acc_guard(acc_guard), .acc_hi(acc_hi), .acc_lo(acc_lo), .ovf(ovf)
  );

  function automatic longint wrap40(longint v);
    longint r = v % SPAN;
    if (r < 0) r += SPAN;
    if (r >= SPAN / 2) r -= SPAN;
    return r;
  endfunction

  function automatic bit beyond32(longint v);
    return (v < -(64'sd1 <<< 31)) || (v > (64'sd1 <<< 31) - 1);
  endfunction

  task automatic check(string tag, longint got, longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic compare(string tag);
    longint dut;
    dut = longint'({acc_guard, acc_hi, acc_lo});
    check(tag, dut, mdl & (SPAN - 1));
    check("R9", longint'(ovf), longint'(beyond32(mdl)));
  endtask

  task automatic step(input bit c, input int o, input int x, input int y,
                      input bit sx, input bit sy, input bit fr,
                      input bit re, input bit ru, input string tag);
    longint a, b, p, r;
    @(negedge clk);
    clr = c; op = 3'(o); opnd_x = 16'(x); opnd_y = 16'(y);
    x_signed = sx; y_signed = sy; frac_mode = fr; rnd_en = re; rnd_unbiased = ru;
    a = sx && x[15] ? longint'(x & 16'hFFFF) - 65536 : longint'(x & 16'hFFFF);
    b = sy && y[15] ? longint'(y & 16'hFFFF) - 65536 : longint'(y & 16'hFFFF);
    p = a * b;
    if (fr) p = p * 2;
    if (c) mdl = 0;
    else if (o >= 1 && o <= 3) begin
      if (o == 1) r = p;
      else if (o == 2) r = mdl + p;
      else r = mdl - p;
      if (re) begin
        bit tie;
        tie = ((r & 64'hFFFF) == 64'h8000);
        r = r + 32768;
        if (ru && tie) r = r & ~(64'sd1 <<< 16);
      end
      mdl = wrap40(r);
    end else if (o == 4 && beyond32(mdl))
      mdl = (mdl < 0) ? -(64'sd1 <<< 31) : (64'sd1 <<< 31) - 1;
    @(posedge clk);
    #1;
    compare(tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    check("R11", longint'(acc_guard), 0);
    rst_n = 1'b1;
    // R3 load under different signedness
    step(0, 1, 3, -5, 1, 1, 0, 0, 0, "R3");
    step(0, 1, 16'hFFFF, 16'hFFFF, 0, 0, 0, 0, 0, "R3");
    step(0, 1, 16'hFFFF, 2, 1, 0, 0, 0, 0, "R3");
    step(0, 1, 16'h8000, 16'h8000, 1, 1, 0, 0, 0, "R3");
    // R4 add and subtract
    step(0, 2, 1000, 1000, 1, 1, 0, 0, 0, "R4");
    step(0, 3, 7, 9, 1, 1, 0, 0, 0, "R4");
    // R5 doubled product
    step(0, 1, 16'h4000, 16'h4000, 1, 1, 1, 0, 0, "R5");
    step(0, 2, 16'h8000, 16'h8000, 1, 1, 1, 0, 0, "R5");
    // R6 hold codes
    step(0, 0, 55, 66, 1, 1, 0, 0, 0, "R6");
    step(0, 5, 55, 66, 1, 1, 0, 1, 0, "R6");
    step(0, 7, 55, 66, 1, 1, 0, 0, 0, "R6");
    // R2 clear beats load
    step(1, 1, 1234, 4321, 1, 1, 0, 0, 0, "R2");
    // R7 and R8 rounding
    step(0, 1, 1, 16'h8000, 0, 0, 0, 1, 0, "R7");
    step(0, 1, 1, 16'h8000, 0, 0, 0, 1, 1, "R8");
    step(0, 1, 1, 16'h8001, 0, 0, 0, 1, 1, "R7");
    step(0, 1, 3, 16'h8000, 0, 0, 0, 1, 1, "R8");
    step(0, 1, 1, 16'h7FFF, 0, 0, 0, 1, 1, "R7");
    // R9 and R10 positive range exceeded then clamped
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    step(0, 4, 0, 0, 0, 0, 0, 0, 0, "R10");
    step(0, 2, 16'h7FFF, 16'h7FFF, 1, 1, 1, 0, 0, "R9");
    step(0, 2, 16'h7FFF, 16'h7FFF, 1, 1, 1, 0, 0, "R9");
    check("R11", longint'(acc_guard), 0);
    check("R11", longint'(acc_hi), 64'hFFFC);
    check("R11", longint'(acc_lo), 4);
    step(0, 4, 0, 0, 0, 0, 0, 0, 0, "R10");
    step(0, 4, 0, 0, 0, 0, 0, 0, 0, "R10");
    // R10 negative side
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    step(0, 3, 16'h7FFF, 16'h7FFF, 1, 1, 1, 0, 0, "R9");
    step(0, 3, 16'h7FFF, 16'h7FFF, 1, 1, 1, 0, 0, "R9");
    step(0, 3, 16'h7FFF, 16'h7FFF, 1, 1, 1, 0, 0, "R9");
    step(0, 4, 0, 0, 0, 0, 0, 0, 0, "R10");
    // R4 wrap through 2^40
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    for (int i = 0; i < 140; i++)
      step(0, 2, 16'hFFFF, 16'hFFFF, 0, 0, 1, 0, 0, "R4");
    for (int i = 0; i < 140; i++)
      step(0, 3, 16'hFFFF, 16'hFFFF, 0, 0, 1, 0, 0, "R4");
    // mixed random traffic
    for (int i = 0; i < 600; i++)
      step(($urandom % 40) == 0, $urandom % 8, $urandom, $urandom,
           1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "R4");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule